// File: doc/BRIEF.md
# ADC FIFO DMA Request Generator

This block sits between an ADC sample FIFO and one DMA channel. It watches the FIFO status flags and raises a request strobe toward the DMA engine whenever the chosen fill condition holds. It also drives a single ADC interrupt event level, whose logic function depends on whether the DMA path is switched on.

A 3-bit control register, loaded through a write strobe, holds three settings. One picks the watermark: any sample present, or the almost-full flag. One switches the DMA path on or off. One picks whether a request goes out as a burst or as a single transfer. The almost-full flag is taken as an input, because the FIFO itself computes its fill level. All outputs are registered. They reflect the inputs and the control value present at the previous rising clock edge.

Top module: `adc_dma_reqgen`

## Requirements
- R1: While `rst` is high at a rising edge, the control register clears to 0 (burst, disabled, not-empty watermark), and `req_burst`, `req_single` and `irq_event` are 0 after that edge.
- R2: When the enable bit (control bit 1) is 0, neither request output is asserted, whatever the FIFO status is.
- R3: With enable at 1 and the watermark bit (control bit 0) at 0, a request is asserted exactly when `fifo_empty` was 0.
- R4: With enable at 1 and the watermark bit at 1, a request is asserted exactly when `fifo_almost_full` was 1, regardless of `fifo_empty`.
- R5: Control bit 2 picks the request output: 0 routes a request to `req_burst` and 1 routes it to `req_single`.
- R6: `req_burst` and `req_single` are never high in the same cycle.
- R7: Each output changes only at a rising edge. Its value after edge k is a function of the inputs and the control value just before edge k. A change on an input between edges leaves the outputs as they are.
- R8: With enable at 1, `irq_event` equals `dma_done` OR `fifo_overflow` OR `fifo_underflow`.
- R9: With enable at 0, `irq_event` equals (NOT `fifo_empty`) OR `fifo_overflow` OR `fifo_underflow`.
- R10: When `ctl_we` is 1 at an edge, `ctl_wdata` is loaded and governs the outputs from the next edge onward. When `ctl_we` is 0, `ctl_wdata` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control value: bit2 single mode, bit1 enable, bit0 almost-full watermark |
| fifo_empty | input | 1 | FIFO holds no sample |
| fifo_almost_full | input | 1 | FIFO is three-quarters full |
| fifo_overflow | input | 1 | FIFO overflow flag |
| fifo_underflow | input | 1 | FIFO underflow flag |
| dma_done | input | 1 | DMA channel done pulse |
| req_burst | output | 1 | Burst request strobe |
| req_single | output | 1 | Single request strobe |
| irq_event | output | 1 | Combined ADC interrupt event level |

## Verification
Random FIFO status is run against random control values. This includes cases where `fifo_empty` and `fifo_almost_full` disagree in ways a real FIFO would not allow, so the bench can tell which flag the watermark actually reads. Cycles where `dma_done` and not-empty disagree show which interrupt function is selected by the enable bit. Directed sequences cover several cases: a write with the strobe low, a mode flip between burst and single while the watermark holds, and an input change between edges that must not reach the outputs before the next edge.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;

    localparam int CTL_W       = 3;
    localparam int CTL_WM_BIT  = 0;
    localparam int CTL_EN_BIT  = 1;
    localparam int CTL_MOD_BIT = 2;

    typedef enum logic {
        WM_NOT_EMPTY   = 1'b0,
        WM_ALMOST_FULL = 1'b1
    } wmark_e;

    typedef enum logic {
        KIND_BURST  = 1'b0,
        KIND_SINGLE = 1'b1
    } req_kind_e;

    // Packed MSB first: bit2 kind, bit1 enable, bit0 watermark
    typedef struct packed {
        req_kind_e kind;
        logic      en;
        wmark_e    wmark;
    } ctl_t;

    typedef struct packed {
        logic empty;
        logic almost_full;
        logic overflow;
        logic underflow;
    } fifo_stat_t;

    typedef struct packed {
        logic burst;
        logic single;
    } req_t;

    localparam ctl_t CTL_RESET = '{kind: KIND_BURST, en: 1'b0, wmark: WM_NOT_EMPTY};

    function automatic ctl_t unpack_ctl(input logic [CTL_W-1:0] raw);
        ctl_t c;
        c.kind  = req_kind_e'(raw[CTL_MOD_BIT]);
        c.en    = raw[CTL_EN_BIT];
        c.wmark = wmark_e'(raw[CTL_WM_BIT]);
        return c;
    endfunction

    function automatic logic watermark_met(input wmark_e wm, input fifo_stat_t st);
        logic met;
        case (wm)
            WM_NOT_EMPTY:   met = ~st.empty;
            WM_ALMOST_FULL: met = st.almost_full;
            default:        met = 1'b0;
        endcase
        return met;
    endfunction

    function automatic logic fault_term(input fifo_stat_t st);
        return st.overflow | st.underflow;
    endfunction

endpackage

// File: rtl/adc_dma_ctl_reg.sv
module adc_dma_ctl_reg
    import adc_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CTL_RESET;
        end else if (we) begin
            ctl <= unpack_ctl(wdata);
        end
    end
endmodule

// File: rtl/adc_dma_req_path.sv
module adc_dma_req_path
    import adc_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctl_t       ctl,
    input  fifo_stat_t st,
    output req_t       req
);
    logic want;
    req_t req_d;

    always_comb begin
        want         = ctl.en & watermark_met(ctl.wmark, st);
        req_d.burst  = want & (ctl.kind == KIND_BURST);
        req_d.single = want & (ctl.kind == KIND_SINGLE);
    end

    always_ff @(posedge clk) begin
        if (rst) req <= '0;
        else     req <= req_d;
    end
endmodule

// File: rtl/adc_dma_irq_path.sv
module adc_dma_irq_path
    import adc_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dma_en,
    input  fifo_stat_t st,
    input  logic       dma_done,
    output logic       irq
);
    logic primary;
    logic irq_d;

    always_comb begin
        primary = dma_en ? dma_done : ~st.empty;
        irq_d   = primary | fault_term(st);
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= irq_d;
    end
endmodule

// File: rtl/adc_dma_reqgen.sv
module adc_dma_reqgen
    import adc_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             fifo_empty,
    input  logic             fifo_almost_full,
    input  logic             fifo_overflow,
    input  logic             fifo_underflow,
    input  logic             dma_done,
    output logic             req_burst,
    output logic             req_single,
    output logic             irq_event
);
    ctl_t       ctl_q;
    fifo_stat_t stat;
    req_t       req_q;
    logic       ctl_en;
    logic       ctl_wm;
    logic       ctl_single;

    assign stat = '{empty: fifo_empty, almost_full: fifo_almost_full,
                    overflow: fifo_overflow, underflow: fifo_underflow};

    adc_dma_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl_q)
    );

    adc_dma_req_path u_req (
        .clk (clk),
        .rst (rst),
        .ctl (ctl_q),
        .st  (stat),
        .req (req_q)
    );

    adc_dma_irq_path u_irq (
        .clk      (clk),
        .rst      (rst),
        .dma_en   (ctl_q.en),
        .st       (stat),
        .dma_done (dma_done),
        .irq      (irq_event)
    );

    assign ctl_en     = ctl_q.en;
    assign ctl_wm     = ctl_q.wmark;
    assign ctl_single = ctl_q.kind;
    assign req_burst  = req_q.burst;
    assign req_single = req_q.single;
endmodule

// File: rtl/adc_dma_reqgen_chk.sv
module adc_dma_reqgen_chk (
    input logic clk,
    input logic rst,
    input logic ctl_we,
    input logic ctl_en,
    input logic ctl_wm,
    input logic ctl_single,
    input logic fifo_empty,
    input logic fifo_almost_full,
    input logic fifo_overflow,
    input logic fifo_underflow,
    input logic dma_done,
    input logic req_burst,
    input logic req_single,
    input logic irq_event
);
    a_r6_one_request: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_burst, req_single}));

    a_r2_off_no_req: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |=> !(req_burst || req_single));

    a_r3_not_empty: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && !ctl_wm) |=> ((req_burst || req_single) == !$past(fifo_empty)));

    a_r4_almost_full: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && ctl_wm) |=> ((req_burst || req_single) == $past(fifo_almost_full)));

    a_r5_single_kind: assert property (@(posedge clk) disable iff (rst)
        ctl_single |=> !req_burst);

    a_r5_burst_kind: assert property (@(posedge clk) disable iff (rst)
        !ctl_single |=> !req_single);

    a_r8_irq_dma_on: assert property (@(posedge clk) disable iff (rst)
        ctl_en |=> (irq_event == $past(dma_done || fifo_overflow || fifo_underflow)));

    a_r9_irq_dma_off: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |=> (irq_event == $past(!fifo_empty || fifo_overflow || fifo_underflow)));

    a_r10_ctl_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> $stable({ctl_en, ctl_wm, ctl_single}));
endmodule

bind adc_dma_reqgen adc_dma_reqgen_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .ctl_we           (ctl_we),
    .ctl_en           (ctl_en),
    .ctl_wm           (ctl_wm),
    .ctl_single       (ctl_single),
    .fifo_empty       (fifo_empty),
    .fifo_almost_full (fifo_almost_full),
    .fifo_overflow    (fifo_overflow),
    .fifo_underflow   (fifo_underflow),
    .dma_done         (dma_done),
    .req_burst        (req_burst),
    .req_single       (req_single),
    .irq_event        (irq_event)
);

// File: tb/adc_dma_reqgen_tb.sv
module adc_dma_reqgen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [2:0] ctl_wdata = 3'b000;
    logic       fifo_empty = 1'b1;
    logic       fifo_almost_full = 1'b0;
    logic       fifo_overflow = 1'b0;
    logic       fifo_underflow = 1'b0;
    logic       dma_done = 1'b0;
    logic       req_burst, req_single, irq_event;

    int total = 0;
    int bad   = 0;
    logic [2:0] m_ctl = 3'b000;
    logic exp_b = 1'b0, exp_s = 1'b0, exp_i = 1'b0;

    always #5 clk = ~clk;

    adc_dma_reqgen u_dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .fifo_empty(fifo_empty), .fifo_almost_full(fifo_almost_full),
        .fifo_overflow(fifo_overflow), .fifo_underflow(fifo_underflow),
        .dma_done(dma_done), .req_burst(req_burst), .req_single(req_single),
        .irq_event(irq_event)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected request from control value (bit2 single, bit1 enable, bit0 almost-full watermark)
    function automatic logic want_req(input logic [2:0] c, input logic e, input logic af);
        if (!c[1]) return 1'b0;
        return c[0] ? af : ~e;
    endfunction

    function automatic logic want_irq(input logic [2:0] c, input logic e, input logic ov,
                                      input logic un, input logic dn);
        return (c[1] ? dn : ~e) | ov | un;
    endfunction

    function automatic string req_tag(input logic [2:0] c);
        if (!c[1]) return "R2";
        return c[0] ? "R4" : "R3";
    endfunction

    // Called at a falling edge: apply, check no change between edges, then check after the edge.
    task automatic step(input logic we, input logic [2:0] wd, input logic e, input logic af,
                        input logic ov, input logic un, input logic dn);
        logic w;
        logic [2:0] used;
        ctl_we = we; ctl_wdata = wd; fifo_empty = e; fifo_almost_full = af;
        fifo_overflow = ov; fifo_underflow = un; dma_done = dn;
        #1;
        chk("R7", "burst between edges", req_burst, exp_b);
        chk("R7", "single between edges", req_single, exp_s);
        chk("R7", "irq between edges", irq_event, exp_i);
        @(posedge clk);
        used  = m_ctl;
        w     = want_req(used, e, af);
        exp_b = w & ~used[2];
        exp_s = w & used[2];
        exp_i = want_irq(used, e, ov, un, dn);
        if (we) m_ctl = wd;
        @(negedge clk);
        chk(req_tag(used), used[2] ? "burst (R5 single mode)" : "burst (R5 burst mode)", req_burst, exp_b);
        chk(req_tag(used), "single", req_single, exp_s);
        chk(used[1] ? "R8" : "R9", "irq", irq_event, exp_i);
        chk("R6", "both requests", req_burst & req_single, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'hADC0_0D3A));
        // R1: reset with active-looking status and a pending write
        rst = 1'b1; ctl_we = 1'b1; ctl_wdata = 3'b111;
        fifo_empty = 1'b0; fifo_almost_full = 1'b1; fifo_overflow = 1'b1; dma_done = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "burst in reset", req_burst, 1'b0);
        chk("R1", "single in reset", req_single, 1'b0);
        chk("R1", "irq in reset", irq_event, 1'b0);
        rst = 1'b0; m_ctl = 3'b000;
        exp_b = 0; exp_s = 0; exp_i = 0;
        // R1: control reset to 0 means disabled, not-empty irq function
        step(1'b0, 3'b111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R1", "irq after reset uses not-empty", irq_event, 1'b1);
        chk("R1", "no request after reset", req_burst | req_single, 1'b0);

        // R10: write with strobe low has no effect
        step(1'b0, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10", "ignored write kept requests off", req_burst, 1'b0);
        // R10: write with strobe high takes effect one edge later
        step(1'b1, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10", "no request on write edge", req_burst, 1'b0);
        step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10", "burst after write", req_burst, 1'b1);

        // R5: flip to single while watermark holds
        step(1'b1, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5", "single selected", req_single, 1'b1);
        chk("R5", "burst dropped", req_burst, 1'b0);

        // R4: almost-full watermark ignores not-empty
        step(1'b1, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R4", "not-empty alone no request", req_burst, 1'b0);
        chk("R8", "done drives irq when on", irq_event, 1'b1);
        step(1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R4", "almost-full requests", req_burst, 1'b1);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic we;
            we = ($urandom % 8) == 0;
            step(we, 3'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 3) == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule